// File: doc/BRIEF.md
# Bridge Error Capture Status Register

This block sits beside the slave port of a bus-to-AXI bridge and records the first error that the bridge meets. It watches incoming burst requests for transfers whose byte range runs past the end of the window mapped to the bridge. It also watches the AXI write and read response channels for the two error codes. The first error found latches a status word, which holds the error kind and the transfer size, master ID and direction of the transaction. The full address of that transaction is latched into a companion error-address register in the same cycle.

The captured information stays frozen until software writes a fixed clear value to the status register. Other errors that arrive before the clear are dropped. An out-of-range burst also raises a combinational flag in the same cycle. The bridge uses this flag to withhold the address acknowledge and to keep the request off AXI, so the upstream arbiter times out and no error response is returned. A one-cycle interrupt pulse marks each capture.

Top module: `brg_err_capture`

## Requirements
- R1: After reset the status word and the error-address register read as zero, and err_irq_o is low.
- R2: Status word layout, with LSB = bit 0: [10:8] transfer size, [7:4] master ID, [3] direction (1 = read, 0 = write), [2] range-overrun flag, [1] decode-error flag, [0] slave-error flag. Bits [31:11] always read zero. reg_sel_i = 0 selects the status word and reg_sel_i = 1 selects the error-address register on reg_rdata_o.
- R3: A burst request (req_valid_i = 1, req_burst_i = 1) with q_addr_i + req_len_i > BASE_ADDR + SPAN_BYTES raises suppress_ack_o in the same cycle, combinationally, and sets the overrun flag. A burst that ends exactly at BASE_ADDR + SPAN_BYTES is not an overrun.
- R4: A single transfer (req_burst_i = 0) never counts as an overrun, whatever its length.
- R5: A response code of 2'b11 (decode error) on a valid response sets flag [1]. A code of 2'b10 (slave error) sets flag [0]. Codes 2'b00 and 2'b01 cause no capture.
- R6: When an error is captured, q_size_i, q_mid_i, q_rnw_i and q_addr_i of that same cycle are latched. They become readable after the next clock edge.
- R7: While any flag is set, both registers hold their values and later errors are ignored.
- R8: A write with reg_sel_i = 0 and data 0xA0000000 clears both registers. Any other data value, and any write with reg_sel_i = 1, changes nothing.
- R9: An error that arrives in the same cycle as a clear write is captured fresh, and its information replaces the old contents.
- R10: Only one flag is recorded per capture. When several errors occur in one cycle, overrun wins over a write-channel error, and a write-channel error wins over a read-channel error.
- R11: err_irq_o is high for exactly the one cycle that follows each capture edge, and the new status is visible in that cycle.
- R12: With BURST_EN = 0, suppress_ack_o stays low and the overrun flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present on the qualifier bus |
| req_burst_i | input | 1 | The request is a burst |
| req_len_i | input | LEN_W | Burst length in bytes |
| q_addr_i | input | ADDR_W | Transaction address |
| q_size_i | input | 3 | Transaction size qualifier |
| q_mid_i | input | 4 | Master ID qualifier |
| q_rnw_i | input | 1 | 1 = read, 0 = write |
| bresp_valid_i | input | 1 | Write response valid |
| bresp_i | input | 2 | Write response code |
| rresp_valid_i | input | 1 | Read response valid |
| rresp_i | input | 2 | Read response code |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = status word, 1 = error address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| err_irq_o | output | 1 | One-cycle capture pulse |
| suppress_ack_o | output | 1 | Withhold acknowledge and AXI issue for this request |

## Verification
The bench drives a burst that ends exactly at the window limit. A design with an off-by-one compare would flag it and stall a legal burst. It also drives an over-long single transfer, which a design that ignored the burst qualifier would suppress. After the first capture, a second error with different qualifiers is sent, and so are clear writes with a near-miss data value or the wrong register select. Any of these would expose a register that overwrites or clears too easily. The bench also checks a clear that lands in the same cycle as an error, and cycles where errors on several sources coincide. These catch a design that loses the fresh error or records more than one flag.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned MID_W  = 4;

  localparam logic [DATA_W-1:0] CLR_MAGIC = 32'hA000_0000;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_SLVERR = 2'b10,
    RSP_DECERR = 2'b11
  } axi_rsp_e;

  typedef struct packed {
    logic ovr;
    logic dec;
    logic slv;
  } err_flags_t;

endpackage

// File: rtl/brg_err_ovr_det.sv
module brg_err_ovr_det #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 12,
  parameter bit          BURST_EN = 1'b1,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
  parameter logic [ADDR_W:0]   SPAN_BYTES = 'h1000
) (
  input  logic              req_valid_i,
  input  logic              req_burst_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ovr_o
);

  localparam logic [ADDR_W:0] LIMIT = {1'b0, BASE_ADDR} + SPAN_BYTES;

  generate
    if (BURST_EN) begin : g_det
      logic [ADDR_W:0] end_excl;
      // one extra bit so a wrap past the top of the address space still compares high
      assign end_excl = {1'b0, addr_i} + (ADDR_W + 1)'(req_len_i);
      assign ovr_o    = req_valid_i && req_burst_i && (end_excl > LIMIT);
    end else begin : g_off
      logic unused_ok;
      assign unused_ok = ^{req_valid_i, req_burst_i, req_len_i, addr_i};
      assign ovr_o     = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/brg_err_rsp_dec.sv
module brg_err_rsp_dec
  import brg_err_pkg::*;
(
  input  logic       ovr_i,
  input  logic       bresp_valid_i,
  input  logic [1:0] bresp_i,
  input  logic       rresp_valid_i,
  input  logic [1:0] rresp_i,
  output err_flags_t evt_o
);

  function automatic err_flags_t classify(input logic vld, input logic [1:0] code);
    err_flags_t f;
    f = '0;
    if (vld) begin
      unique case (axi_rsp_e'(code))
        RSP_DECERR: f.dec = 1'b1;
        RSP_SLVERR: f.slv = 1'b1;
        default:    f = '0;
      endcase
    end
    return f;
  endfunction

  err_flags_t wr_f, rd_f;

  assign wr_f = classify(bresp_valid_i, bresp_i);
  assign rd_f = classify(rresp_valid_i, rresp_i);

  // fixed priority: overrun, then write channel, then read channel
  always_comb begin
    evt_o = '0;
    if (ovr_i)              evt_o.ovr = 1'b1;
    else if (wr_f != '0)    evt_o = wr_f;
    else                    evt_o = rd_f;
  end

endmodule

// File: rtl/brg_err_regs.sv
module brg_err_regs
  import brg_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  err_flags_t        evt_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] q_addr_i,
  input  logic [SIZE_W-1:0] q_size_i,
  input  logic [MID_W-1:0]  q_mid_i,
  input  logic              q_rnw_i,
  output err_flags_t        flags_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [MID_W-1:0]  mid_o,
  output logic              rnw_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              irq_o
);

  err_flags_t        flags_q;
  logic [SIZE_W-1:0] size_q;
  logic [MID_W-1:0]  mid_q;
  logic              rnw_q;
  logic [ADDR_W-1:0] addr_q;
  logic              irq_q;
  logic              held;
  logic              capture;

  // a clear in this cycle frees the register for an error of this cycle
  assign held    = (flags_q != '0) && !clr_i;
  assign capture = (evt_i != '0) && !held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      size_q  <= '0;
      mid_q   <= '0;
      rnw_q   <= 1'b0;
      addr_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= capture;
      if (capture) begin
        flags_q <= evt_i;
        size_q  <= q_size_i;
        mid_q   <= q_mid_i;
        rnw_q   <= q_rnw_i;
        addr_q  <= q_addr_i;
      end else if (clr_i) begin
        flags_q <= '0;
        size_q  <= '0;
        mid_q   <= '0;
        rnw_q   <= 1'b0;
        addr_q  <= '0;
      end
    end
  end

  assign flags_o = flags_q;
  assign size_o  = size_q;
  assign mid_o   = mid_q;
  assign rnw_o   = rnw_q;
  assign addr_o  = addr_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/brg_err_capture.sv
module brg_err_capture
  import brg_err_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 12,
  parameter bit          BURST_EN = 1'b1,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
  parameter logic [ADDR_W:0]   SPAN_BYTES = 'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_burst_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [ADDR_W-1:0] q_addr_i,
  input  logic [2:0]        q_size_i,
  input  logic [3:0]        q_mid_i,
  input  logic              q_rnw_i,
  input  logic              bresp_valid_i,
  input  logic [1:0]        bresp_i,
  input  logic              rresp_valid_i,
  input  logic [1:0]        rresp_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              err_irq_o,
  output logic              suppress_ack_o
);

  logic              ovr;
  err_flags_t        evt;
  err_flags_t        flags;
  logic [SIZE_W-1:0] size_q;
  logic [MID_W-1:0]  mid_q;
  logic              rnw_q;
  logic [ADDR_W-1:0] addr_word;
  logic [DATA_W-1:0] stat_word;
  logic              clr_hit;
  logic              evt_any;

  brg_err_ovr_det #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .BURST_EN  (BURST_EN),
    .BASE_ADDR (BASE_ADDR),
    .SPAN_BYTES(SPAN_BYTES)
  ) u_ovr (
    .req_valid_i(req_valid_i),
    .req_burst_i(req_burst_i),
    .req_len_i  (req_len_i),
    .addr_i     (q_addr_i),
    .ovr_o      (ovr)
  );

  brg_err_rsp_dec u_dec (
    .ovr_i        (ovr),
    .bresp_valid_i(bresp_valid_i),
    .bresp_i      (bresp_i),
    .rresp_valid_i(rresp_valid_i),
    .rresp_i      (rresp_i),
    .evt_o        (evt)
  );

  assign clr_hit = reg_we_i && !reg_sel_i && (reg_wdata_i == CLR_MAGIC);
  assign evt_any = (evt != '0);

  brg_err_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .clr_i   (clr_hit),
    .q_addr_i(q_addr_i),
    .q_size_i(q_size_i),
    .q_mid_i (q_mid_i),
    .q_rnw_i (q_rnw_i),
    .flags_o (flags),
    .size_o  (size_q),
    .mid_o   (mid_q),
    .rnw_o   (rnw_q),
    .addr_o  (addr_word),
    .irq_o   (err_irq_o)
  );

  always_comb begin
    stat_word       = '0;
    stat_word[10:8] = size_q;
    stat_word[7:4]  = mid_q;
    stat_word[3]    = rnw_q;
    stat_word[2]    = flags.ovr;
    stat_word[1]    = flags.dec;
    stat_word[0]    = flags.slv;
  end

  assign reg_rdata_o    = reg_sel_i ? DATA_W'(addr_word) : stat_word;
  assign suppress_ack_o = ovr;

endmodule

// File: rtl/brg_err_capture_chk.sv
module brg_err_capture_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter bit          BURST_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_burst_i,
  input logic              suppress_ack_o,
  input logic              err_irq_o,
  input logic [31:0]       stat_word,
  input logic [ADDR_W-1:0] addr_word,
  input logic              clr_hit,
  input logic              evt_any
);

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_word[31:11] == '0);

  a_r4_suppress_burst_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_ack_o |-> (req_valid_i && req_burst_i));

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_word[2:0] != '0) && !clr_hit) |=> ($stable(stat_word) && $stable(addr_word)));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && !evt_any) |=> ((stat_word == '0) && (addr_word == '0)));

  a_r10_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat_word[2:0]));

  a_r11_irq_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (stat_word[2:0] != '0));

  a_r11_irq_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_irq_o) |-> $past(evt_any));

  generate
    if (!BURST_EN) begin : g_nob
      a_r12_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !suppress_ack_o && !stat_word[2]);
    end
  endgenerate

endmodule

bind brg_err_capture brg_err_capture_chk #(
  .ADDR_W  (ADDR_W),
  .BURST_EN(BURST_EN)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_burst_i   (req_burst_i),
  .suppress_ack_o(suppress_ack_o),
  .err_irq_o     (err_irq_o),
  .stat_word     (stat_word),
  .addr_word     (addr_word),
  .clr_hit       (clr_hit),
  .evt_any       (evt_any)
);

// File: tb/brg_err_capture_tb.sv
`timescale 1ns/1ps
module brg_err_capture_tb;

  localparam logic [31:0] BASE  = 32'h1000_0000;
  localparam logic [32:0] SPAN  = 33'h0000_1000;
  localparam logic [32:0] LIMIT = {1'b0, BASE} + SPAN;
  localparam logic [31:0] MAGIC = 32'hA000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_burst;
  logic [11:0] req_len;
  logic [31:0] q_addr;
  logic [2:0]  q_size;
  logic [3:0]  q_mid;
  logic        q_rnw;
  logic        b_valid, r_valid;
  logic [1:0]  b_resp, r_resp;
  logic        reg_we, reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] rdata, nob_rdata;
  logic        irq, supp, nob_irq, nob_supp;

  always #2 clk = ~clk;

  brg_err_capture #(.BASE_ADDR(BASE), .SPAN_BYTES(SPAN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_burst_i(req_burst),
    .req_len_i(req_len), .q_addr_i(q_addr), .q_size_i(q_size), .q_mid_i(q_mid),
    .q_rnw_i(q_rnw), .bresp_valid_i(b_valid), .bresp_i(b_resp), .rresp_valid_i(r_valid),
    .rresp_i(r_resp), .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .err_irq_o(irq), .suppress_ack_o(supp));

  brg_err_capture #(.BASE_ADDR(BASE), .SPAN_BYTES(SPAN), .BURST_EN(1'b0)) u_dut_nob (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_burst_i(req_burst),
    .req_len_i(req_len), .q_addr_i(q_addr), .q_size_i(q_size), .q_mid_i(q_mid),
    .q_rnw_i(q_rnw), .bresp_valid_i(b_valid), .bresp_i(b_resp), .rresp_valid_i(r_valid),
    .rresp_i(r_resp), .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(nob_rdata), .err_irq_o(nob_irq), .suppress_ack_o(nob_supp));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state, kept from the requirements
  logic [31:0] m_stat = '0;
  logic [31:0] m_addr = '0;

  logic [31:0] sb_rdata[$];
  bit          sb_irq[$];
  bit          sb_supp[$];
  string       sb_tag[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_burst = 0; req_len = '0; q_addr = '0; q_size = '0; q_mid = '0;
    q_rnw = 0; b_valid = 0; b_resp = '0; r_valid = 0; r_resp = '0;
    reg_we = 0; reg_sel = 0; reg_wdata = '0;
  endtask

  // driver: inputs already set this half cycle; predict the post-edge view
  task automatic step(input string tag);
    logic [32:0] end_excl;
    bit ovr, clr, cap;
    logic [2:0] ev;
    logic [31:0] nxt_s, nxt_a;
    end_excl = {1'b0, q_addr} + {21'd0, req_len};
    ovr = req_valid && req_burst && (end_excl > LIMIT);
    ev = 3'b000;
    if (ovr) ev = 3'b100;
    else if (b_valid && b_resp[1]) ev = (b_resp == 2'b11) ? 3'b010 : 3'b001;
    else if (r_valid && r_resp[1]) ev = (r_resp == 2'b11) ? 3'b010 : 3'b001;
    clr = reg_we && !reg_sel && (reg_wdata == MAGIC);
    nxt_s = clr ? '0 : m_stat;
    nxt_a = clr ? '0 : m_addr;
    cap = (ev != 0) && (nxt_s[2:0] == 0);
    if (cap) begin
      nxt_s = {21'd0, q_size, q_mid, q_rnw, ev};
      nxt_a = q_addr;
    end
    m_stat = nxt_s;
    m_addr = nxt_a;
    sb_rdata.push_back(reg_sel ? m_addr : m_stat);
    sb_irq.push_back(cap);
    sb_supp.push_back(ovr);
    sb_tag.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb_tag.size() > 0) begin
      logic [31:0] er;
      bit ei, es;
      string t;
      er = sb_rdata.pop_front(); ei = sb_irq.pop_front(); es = sb_supp.pop_front();
      t = sb_tag.pop_front();
      check(rdata == er && irq == ei && supp == es, t,
            {31'd0, irq, supp, rdata}, {31'd0, ei, es, er});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    @(negedge clk); idle(); step("R1 reset status");
    @(negedge clk); idle(); reg_sel = 1; step("R1 reset address");

    @(negedge clk); idle(); b_valid = 1; b_resp = 2'b00; r_valid = 1; r_resp = 2'b01;
    step("R5 okay/exokay no capture");

    @(negedge clk); idle(); req_valid = 1; req_burst = 0; q_addr = 32'h1000_0FF0; req_len = 12'h100;
    step("R4 single transfer past limit");

    @(negedge clk); idle(); req_valid = 1; req_burst = 1; q_addr = 32'h1000_0F00; req_len = 12'h100;
    step("R3 burst ends at limit");

    @(negedge clk); idle(); req_valid = 1; req_burst = 1; q_addr = 32'h1000_0F80; req_len = 12'h100;
    q_size = 3'b101; q_mid = 4'hA; q_rnw = 1;
    step("R3 R6 R11 burst overrun capture");
    #1 check(nob_supp == 1'b0, "R12 suppress with bursts off", {63'd0, nob_supp}, 64'd0);
    @(posedge clk); #2 check(nob_rdata == 32'd0, "R12 no overrun flag with bursts off", {32'd0, nob_rdata}, 64'd0);

    @(negedge clk); idle(); reg_sel = 1; step("R6 R11 address latched, pulse ends");

    @(negedge clk); idle(); r_valid = 1; r_resp = 2'b11; q_size = 3'b001; q_mid = 4'h2; q_addr = 32'h44;
    step("R7 later decode error ignored");
    @(negedge clk); idle(); req_valid = 1; req_burst = 1; q_addr = 32'h1000_0FFF; req_len = 12'h010;
    step("R7 later overrun ignored but suppressed");
    @(negedge clk); idle(); reg_sel = 1; step("R7 address frozen");

    @(negedge clk); idle(); reg_we = 1; reg_wdata = 32'hA000_0001; step("R8 near-miss value no clear");
    @(negedge clk); idle(); reg_we = 1; reg_sel = 1; reg_wdata = MAGIC; step("R8 magic to address reg no clear");
    @(negedge clk); idle(); reg_we = 1; reg_wdata = MAGIC; step("R8 magic clears status");
    @(negedge clk); idle(); reg_sel = 1; step("R8 magic clears address");

    @(negedge clk); idle(); b_valid = 1; b_resp = 2'b11; q_size = 3'b010; q_mid = 4'h3; q_addr = 32'h20;
    step("R5 R2 write decode error");
    @(negedge clk); idle(); reg_we = 1; reg_wdata = MAGIC; step("R8 clear");
    @(negedge clk); idle(); r_valid = 1; r_resp = 2'b10; q_size = 3'b001; q_mid = 4'hF; q_rnw = 1;
    q_addr = 32'hDEAD_BEE0; step("R5 R2 read slave error");

    @(negedge clk); idle(); reg_we = 1; reg_wdata = MAGIC; b_valid = 1; b_resp = 2'b10;
    q_mid = 4'h1; q_addr = 32'h0000_0100; step("R9 error during clear captured");
    @(negedge clk); idle(); reg_sel = 1; step("R9 fresh address");

    @(negedge clk); idle(); reg_we = 1; reg_wdata = MAGIC; step("R8 clear");
    @(negedge clk); idle(); req_valid = 1; req_burst = 1; q_addr = 32'h1000_0FFF; req_len = 12'h002;
    b_valid = 1; b_resp = 2'b11; r_valid = 1; r_resp = 2'b10; step("R10 overrun wins");
    @(negedge clk); idle(); reg_we = 1; reg_wdata = MAGIC; step("R8 clear");
    @(negedge clk); idle(); b_valid = 1; b_resp = 2'b10; r_valid = 1; r_resp = 2'b11; q_mid = 4'h6;
    step("R10 write channel wins");
    @(negedge clk); idle(); step("R11 no repeat pulse");

    @(negedge clk); idle();
    @(posedge clk); #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule